// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the control registers of a memory-management unit and serves them through an alternate-space load/store port. Each request carries a kind, a write flag, a 32-bit address and a 32-bit write word. A request of kind register access selects one of sixteen 32-bit registers. The selector is the 4-bit field at address bits [11:8]. Most registers are plain storage. Three have special behaviour: the control register (index 0), the context register (index 2) and the fault-status register (index 3).

Two further request kinds carry MMU commands. A flush command asks the translation cache to drop entries. A probe command asks the table walker to look up an address. Both take their level from address bits [11:8] and their virtual page number from address bits [31:12]. The block reports these as single-cycle pulses. A flush pulse is also raised when a register write changes the control or context value. The page-table walk, the TLB storage and the physical memory path sit outside this block.

The port is always ready once reset has ended. Requests are accepted one per cycle. Every response and every pulse is registered, so it appears in the cycle after the accepting clock edge.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After a synchronous reset, `req_ready` is high from the first cycle after reset is released. At that point the control register reads CTRL_RESET (default 0xA0000000), the context and fault-status registers read 0, and no pulse is active.
- R2: A register read (`req_kind`=0, `req_write`=0) gives `rsp_valid` high for one cycle, one cycle after acceptance. `rsp_rdata` carries the stored value. A write to a plain register stores the full 32-bit word. Writes produce no response.
- R3: The register index is address bits [11:8]. All other address bits have no effect on which register is accessed.
- R4: A read of the fault-status register (index 3) returns its value and leaves it at zero, so the next read returns 0.
- R5: A write to the control register (index 0) changes only bit 0 (translation enable) and bit 1 (no-fault mode). Bits [31:2] keep their previous value.
- R6: A control write that changes the stored value raises `flush_valid` with `flush_level`=4 and `flush_page`=0 in the next cycle. A control write that leaves the stored value unchanged raises no pulse. This includes a write that differs only in the masked bits.
- R7: A write that changes the context register (index 2) raises a level-4 full flush pulse. A write of the same value raises none.
- R8: A flush command (`req_kind`=1) with level 0 raises `flush_valid` with `flush_level`=0 and `flush_page` equal to address bits [31:12].
- R9: A flush command with level 1, 2, 3 or 4 raises a full flush: `flush_level` equals the commanded level and `flush_page`=0. Levels 5 to 15 raise no pulse.
- R10: A probe command (`req_kind`=2) raises `probe_valid` for one cycle. `probe_level` is address bits [11:8] and `probe_vpn` is address bits [31:12]. The same command gives a response with `rsp_rdata`=0.
- R11: The `flush_valid`, `probe_valid` and `rsp_valid` pulses last exactly one cycle. They only ever follow an accepted request. Kind 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_kind | input | 2 | 0 register, 1 flush command, 2 probe command, 3 none |
| req_write | input | 1 | Register write when high, read when low |
| req_addr | input | 32 | Access address (index/level at [11:8], page at [31:12]) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read or probe response |
| rsp_rdata | output | 32 | Response data |
| flush_valid | output | 1 | TLB flush request pulse |
| flush_level | output | 4 | 0 single page, 1..4 full flush |
| flush_page | output | 20 | Page number for a level-0 flush, else 0 |
| probe_valid | output | 1 | Probe request pulse |
| probe_level | output | 4 | Probe level |
| probe_vpn | output | 20 | Probe virtual page number |

## Verification
A corrupted stored value is visible on the next read of that register. The data arrives one cycle after the read is accepted, so the bench writes every index and reads each one back.

A wrong change detector on the control or context register shows up differently depending on its fault. It either misses the flush pulse in the cycle after the write, or raises a spurious pulse when a write leaves the value unchanged.

A clear-on-read fault takes two reads to show: the second read of the fault-status register returns a non-zero value. Level decoding faults are exposed by sweeping all sixteen flush and probe levels.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  typedef enum logic [1:0] {
    K_REG   = 2'b00,
    K_FLUSH = 2'b01,
    K_PROBE = 2'b10,
    K_NONE  = 2'b11
  } req_kind_e;

  localparam int unsigned LVL_PAGE = 0;
  localparam int unsigned LVL_ALL  = 4;
endpackage

// File: rtl/mmu_req_decode.sv
module mmu_req_decode #(
  parameter int unsigned AW       = 32,
  parameter int unsigned IDX_LSB  = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned PAGE_LSB = 12,
  localparam int unsigned PAGE_W  = AW - PAGE_LSB
) (
  input  logic                 fire,
  input  logic [1:0]           kind,
  input  logic                 write,
  input  logic [IDX_W-1:0]     field,
  input  logic [PAGE_W-1:0]    page_in,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic                 page_cmd,
  output logic                 full_cmd,
  output logic                 probe_cmd,
  output logic [IDX_W-1:0]     sel,
  output logic [PAGE_W-1:0]    vpn
);
  import mmu_ctl_pkg::*;

  logic is_reg, is_flush, lvl_zero, lvl_full;

  always_comb begin
    is_reg    = fire && (kind == K_REG);
    is_flush  = fire && (kind == K_FLUSH);
    lvl_zero  = (field == IDX_W'(LVL_PAGE));
    lvl_full  = !lvl_zero && (field <= IDX_W'(LVL_ALL));
    reg_wr    = is_reg && write;
    reg_rd    = is_reg && !write;
    page_cmd  = is_flush && lvl_zero;
    full_cmd  = is_flush && lvl_full;
    probe_cmd = fire && (kind == K_PROBE);
    sel       = field;
    vpn       = page_in;
  end
endmodule

// File: rtl/mmu_reg_store.sv
module mmu_reg_store #(
  parameter int unsigned    DW         = 32,
  parameter int unsigned    IDX_W      = 4,
  parameter int unsigned    CTRL_IDX   = 0,
  parameter int unsigned    CTX_IDX    = 2,
  parameter int unsigned    FSR_IDX    = 3,
  parameter logic [DW-1:0]  CTRL_WMASK = 32'h0000_0003,
  parameter logic [DW-1:0]  CTRL_RESET = 32'hA000_0000,
  localparam int unsigned   NREG       = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             probe_rd,
  input  logic [IDX_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             ctrl_chg,
  output logic             ctx_chg
);
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] ctrl_q, ctx_q, fsr_q, ctrl_next;
  logic          hit_ctrl, hit_ctx, hit_fsr;

  always_comb begin
    hit_ctrl  = (sel == IDX_W'(CTRL_IDX));
    hit_ctx   = (sel == IDX_W'(CTX_IDX));
    hit_fsr   = (sel == IDX_W'(FSR_IDX));
    ctrl_next = (ctrl_q & ~CTRL_WMASK) | (wdata & CTRL_WMASK);
    ctrl_chg  = reg_wr && hit_ctrl && (ctrl_next != ctrl_q);
    ctx_chg   = reg_wr && hit_ctx && (wdata != ctx_q);
  end

  // plain storage, no reset, single write port
  always_ff @(posedge clk) begin
    if (reg_wr) mem[sel] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      ctx_q  <= '0;
      fsr_q  <= '0;
    end else if (reg_wr) begin
      if (hit_ctrl) ctrl_q <= ctrl_next;
      if (hit_ctx)  ctx_q  <= wdata;
      if (hit_fsr)  fsr_q  <= wdata;
    end else if (reg_rd && hit_fsr) begin
      fsr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (reg_rd) begin
      if (hit_ctrl)     rdata <= ctrl_q;
      else if (hit_ctx) rdata <= ctx_q;
      else if (hit_fsr) rdata <= fsr_q;
      else              rdata <= mem[sel];
    end else if (probe_rd) begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/mmu_event_out.sv
module mmu_event_out #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_cmd,
  input  logic              full_cmd,
  input  logic              probe_cmd,
  input  logic              reg_chg,
  input  logic [IDX_W-1:0]  lvl,
  input  logic [PAGE_W-1:0] vpn,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_level,
  output logic [PAGE_W-1:0] flush_page,
  output logic              probe_valid,
  output logic [IDX_W-1:0]  probe_level,
  output logic [PAGE_W-1:0] probe_vpn
);
  import mmu_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_valid <= 1'b0;
      flush_level <= '0;
      flush_page  <= '0;
      probe_valid <= 1'b0;
      probe_level <= '0;
      probe_vpn   <= '0;
    end else begin
      flush_valid <= page_cmd || full_cmd || reg_chg;
      flush_level <= reg_chg ? IDX_W'(LVL_ALL) : (page_cmd || full_cmd) ? lvl : '0;
      flush_page  <= page_cmd ? vpn : '0;
      probe_valid <= probe_cmd;
      probe_level <= probe_cmd ? lvl : '0;
      probe_vpn   <= probe_cmd ? vpn : '0;
    end
  end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int unsigned   DW         = 32,
  parameter int unsigned   AW         = 32,
  parameter int unsigned   IDX_LSB    = 8,
  parameter int unsigned   IDX_W      = 4,
  parameter int unsigned   PAGE_LSB   = 12,
  parameter int unsigned   CTRL_IDX   = 0,
  parameter int unsigned   CTX_IDX    = 2,
  parameter int unsigned   FSR_IDX    = 3,
  parameter logic [DW-1:0] CTRL_WMASK = 32'h0000_0003,
  parameter logic [DW-1:0] CTRL_RESET = 32'hA000_0000,
  localparam int unsigned  PAGE_W     = AW - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_level,
  output logic [PAGE_W-1:0] flush_page,
  output logic              probe_valid,
  output logic [IDX_W-1:0]  probe_level,
  output logic [PAGE_W-1:0] probe_vpn
);
  logic              fire, reg_wr, reg_rd, page_cmd, full_cmd, probe_cmd;
  logic              ctrl_chg, ctx_chg;
  logic [IDX_W-1:0]  sel;
  logic [PAGE_W-1:0] vpn;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  assign fire = req_valid && req_ready;

  mmu_req_decode #(
    .AW(AW), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .PAGE_LSB(PAGE_LSB)
  ) u_dec (
    .fire(fire), .kind(req_kind), .write(req_write),
    .field(req_addr[IDX_LSB +: IDX_W]), .page_in(req_addr[AW-1:PAGE_LSB]),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .page_cmd(page_cmd),
    .full_cmd(full_cmd), .probe_cmd(probe_cmd), .sel(sel), .vpn(vpn)
  );

  mmu_reg_store #(
    .DW(DW), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .CTX_IDX(CTX_IDX),
    .FSR_IDX(FSR_IDX), .CTRL_WMASK(CTRL_WMASK), .CTRL_RESET(CTRL_RESET)
  ) u_store (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .probe_rd(probe_cmd), .sel(sel), .wdata(req_wdata),
    .rdata(rsp_rdata), .ctrl_chg(ctrl_chg), .ctx_chg(ctx_chg)
  );

  mmu_event_out #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_evt (
    .clk(clk), .rst(rst), .page_cmd(page_cmd), .full_cmd(full_cmd),
    .probe_cmd(probe_cmd), .reg_chg(ctrl_chg || ctx_chg), .lvl(sel), .vpn(vpn),
    .flush_valid(flush_valid), .flush_level(flush_level), .flush_page(flush_page),
    .probe_valid(probe_valid), .probe_level(probe_level), .probe_vpn(probe_vpn)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= reg_rd || probe_cmd;
  end
endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PAGE_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic              flush_valid,
  input logic [IDX_W-1:0]  flush_level,
  input logic [PAGE_W-1:0] flush_page,
  input logic              probe_valid,
  input logic [IDX_W-1:0]  probe_level
);
  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> req_ready);

  // R11
  flush_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(req_valid && req_ready && req_kind != 2'b11));

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready &&
                        (req_kind == 2'b10 || (req_kind == 2'b00 && !req_write))));

  // R9
  flush_level_range_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (flush_level <= IDX_W'(4)));

  // R8
  full_flush_page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_valid && flush_level != '0) |-> (flush_page == '0));

  // R10
  probe_response_chk: assert property (@(posedge clk) disable iff (rst)
    probe_valid |-> (rsp_valid && rsp_rdata == '0 &&
                     probe_level == $past(req_addr[11:8])));
endmodule

bind mmu_ctl_regs mmu_ctl_chk #(
  .DW(DW), .AW(AW), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flush_valid(flush_valid),
  .flush_level(flush_level), .flush_page(flush_page),
  .probe_valid(probe_valid), .probe_level(probe_level)
);

// File: tb/sim_mmu_ctl_regs.sv
module sim_mmu_ctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b11;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        flush_valid;
  logic [3:0]  flush_level;
  logic [19:0] flush_page;
  logic        probe_valid;
  logic [3:0]  probe_level;
  logic [19:0] probe_vpn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mmu_ctl_regs u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, accept at next posedge, sample at the following negedge
  task automatic access(logic [1:0] k, logic w, logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_kind = k; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'b11;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h0F0F_5A5A;
  endfunction

  function automatic logic [31:0] raddr(int i);
    return {20'hABCDE ^ 20'(i * 7), 4'(i), 8'h5C};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle();
    // R1 reset state
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 no flush", {31'd0, flush_valid}, 32'd0);
    check("R1 no probe", {31'd0, probe_valid}, 32'd0);
    access(2'b00, 1'b0, raddr(0), 0);
    check("R1 ctrl reset", rsp_rdata, 32'hA000_0000);
    access(2'b00, 1'b0, raddr(2), 0);
    check("R1 ctx reset", rsp_rdata, 32'h0);
    access(2'b00, 1'b0, raddr(3), 0);
    check("R1 fsr reset", rsp_rdata, 32'h0);

    // R2 R3 R5 R6 R7: write every index, then read all back
    for (int i = 0; i < 16; i++) begin
      logic exp_fl;
      exp_fl = (i == 2) || (i == 0 && pat(i)[1:0] != 2'b00);
      access(2'b00, 1'b1, raddr(i), pat(i));
      check("R2 no write rsp", {31'd0, rsp_valid}, 32'd0);
      check("R6 R7 flush on change", {31'd0, flush_valid}, {31'd0, exp_fl});
      if (exp_fl) check("R6 R7 full level", {28'd0, flush_level}, 32'd4);
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = (i == 0) ? ((32'hA000_0000) | (pat(0) & 32'h3)) : pat(i);
      access(2'b00, 1'b0, raddr(i) ^ 32'hFFFF_F0FF, 0);
      check("R2 rsp valid", {31'd0, rsp_valid}, 32'd1);
      check(i == 0 ? "R5 masked ctrl" : "R3 R2 readback", rsp_rdata, e);
      idle();
      check("R11 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
    end
    // R4 cleared by previous read
    access(2'b00, 1'b0, raddr(3), 0);
    check("R4 fsr cleared", rsp_rdata, 32'h0);

    // R5 R6 control masking and change detect
    access(2'b00, 1'b1, raddr(0), 32'h0000_0000);
    access(2'b00, 1'b1, raddr(0), 32'h5555_5551);
    check("R6 change flush", {31'd0, flush_valid}, 32'd1);
    check("R6 level", {28'd0, flush_level}, 32'd4);
    check("R6 page zero", {12'd0, flush_page}, 32'd0);
    idle();
    check("R11 flush one cycle", {31'd0, flush_valid}, 32'd0);
    access(2'b00, 1'b1, raddr(0), 32'hFFFF_FFFD);
    check("R6 masked-only write no flush", {31'd0, flush_valid}, 32'd0);
    access(2'b00, 1'b0, raddr(0), 0);
    check("R5 ctrl upper bits kept", rsp_rdata, 32'hA000_0001);

    // R7 same context value
    access(2'b00, 1'b1, raddr(2), pat(2));
    check("R7 same ctx no flush", {31'd0, flush_valid}, 32'd0);
    access(2'b00, 1'b1, raddr(2), 32'h0000_0042);
    check("R7 ctx change flush", {31'd0, flush_valid}, 32'd1);

    // R8 R9 flush level sweep
    for (int l = 0; l < 16; l++) begin
      logic [19:0] v;
      v = 20'h12345 + 20'(l * 4099);
      access(2'b01, 1'b0, {v, 4'(l), 8'h00}, 0);
      check(l == 0 ? "R8 page flush" : "R9 level gate", {31'd0, flush_valid},
            {31'd0, (l <= 4)});
      if (l <= 4) begin
        check("R8 R9 level", {28'd0, flush_level}, l);
        check("R8 R9 page", {12'd0, flush_page}, (l == 0) ? {12'd0, v} : 32'd0);
      end
      check("R9 no response", {31'd0, rsp_valid}, 32'd0);
    end

    // R10 probe sweep
    for (int l = 0; l < 16; l++) begin
      logic [19:0] v;
      v = 20'hFEDCB - 20'(l * 311);
      access(2'b10, 1'b0, {v, 4'(l), 8'hA5}, 0);
      check("R10 probe pulse", {31'd0, probe_valid}, 32'd1);
      check("R10 probe level", {28'd0, probe_level}, l);
      check("R10 probe vpn", {12'd0, probe_vpn}, {12'd0, v});
      check("R10 rsp zero", rsp_rdata, 32'h0);
      check("R10 no flush", {31'd0, flush_valid}, 32'd0);
    end
    idle();
    check("R11 probe one cycle", {31'd0, probe_valid}, 32'd0);

    // R11 kind 3 has no effect
    access(2'b11, 1'b1, raddr(5), 32'hDEAD_BEEF);
    check("R11 kind3 quiet", {29'd0, rsp_valid, flush_valid, probe_valid}, 32'd0);
    access(2'b00, 1'b0, raddr(5), 0);
    check("R11 kind3 no write", rsp_rdata, pat(5));

    // R4 write then double read
    access(2'b00, 1'b1, raddr(3), 32'h0000_0C2D);
    access(2'b00, 1'b0, raddr(3), 0);
    check("R4 fsr value", rsp_rdata, 32'h0000_0C2D);
    access(2'b00, 1'b0, raddr(3), 0);
    check("R4 fsr clear on read", rsp_rdata, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule